// File: doc/BRIEF.md
# Sensed Interrupt Line Bank

This block collects up to 32 active-low interrupt request lines and turns them into pending bits that a separate priority resolver consumes. Each line is set up through its own configuration word as edge-sensitive (a falling edge on the request pin) or level-sensitive (a low level). Each word also steers the line to the normal or the fast interrupt channel and gives it a priority. A mask register and a pending register complete the line state. Software can inject interrupts, and it can clear pending bits with an AND-style write.

The block exports the pending, mask, steering and priority vectors, plus a one-cycle re-evaluation pulse. The resolver returns the winning line index for each channel. When software reads a channel's code register, it gets that winner, and the read acknowledges the winner when the winner is edge-sensitive. A clear written while a level-sensitive request is still low cannot remove that line's pending bit.

Top module: `irq_line_bank`

## Requirements
- R1: After reset, pending, raw-input, sensitivity and steering bits are all 0. The mask is all ones, every priority is 0 and the re-evaluation pulse is low.
- R2: A write to byte offset 0x1C + 4·i sets line i: priority from bits [6:2], sensitivity from bit 1 (0 = falling edge, 1 = low level), steering from bit 0 (1 = fast channel). A read returns only those bits, and no other line's settings change.
- R3: A write to the pending register (offset 0x00) leaves pending = old pending AND (written value OR (raw input AND level bits)). A level line whose request is still low keeps its pending bit.
- R4: A read of offset 0x10 returns the normal-channel winner index, and a read of offset 0x14 returns the fast-channel winner index. Either read clears that winner's pending bit in the next cycle when the winner is edge-sensitive.
- R5: A pending bit is raised only when the request goes low after having been high at the previous sample. A request held low does not raise it again after it was cleared.
- R6: A write to offset 0x0C sets the pending bits of every line whose written bit is 1.
- R7: Offset 0x04 is the mask register. Writes replace it, reads return it, and `mask_o` follows it.
- R8: `reeval_o` is high for the cycle after any cycle in which pending changes or the mask or a configuration word is written. It is low otherwise.
- R9: A code read whose winner is level-sensitive leaves that winner's pending bit set.
- R10: Offset 0x08 reads the raw-input record, 1 for each line whose request was low at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n_i | input | NLINES | Active-low interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (needed only for acknowledge side effects) |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| irq_win_i | input | IDX_W | Normal-channel winner from the resolver |
| fiq_win_i | input | IDX_W | Fast-channel winner from the resolver |
| pend_o | output | NLINES | Pending vector |
| mask_o | output | NLINES | Mask vector (1 = masked) |
| steer_o | output | NLINES | Channel steering (1 = fast channel) |
| prio_o | output | NLINES*PRIO_W | Priorities, line i at bits [i*PRIO_W +: PRIO_W] |
| reeval_o | output | 1 | Re-evaluation request pulse |

## Verification
Every registered result moves on the first clock edge after its stimulus. Pending bits, raw-input records, mask, configuration words and the re-evaluation pulse all fall in this group. The bench drives a stimulus just after a falling edge and checks those results at the next falling edge. Read data is combinational from current state, so it is sampled 1 ns after the read is driven, before the edge that commits any acknowledge. The acknowledge effect is then checked on the following falling edge.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  // Register byte offsets
  localparam int OFF_PEND     = 'h00;
  localparam int OFF_MASK     = 'h04;
  localparam int OFF_RAW      = 'h08;
  localparam int OFF_SWSET    = 'h0C;
  localparam int OFF_IRQ_CODE = 'h10;
  localparam int OFF_FIQ_CODE = 'h14;
  localparam int OFF_CFG_BASE = 'h1C;

  // Configuration word field positions
  localparam int CFG_STEER_BIT = 0;
  localparam int CFG_SENSE_BIT = 1;
  localparam int CFG_PRIO_LSB  = 2;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;

endpackage

// File: rtl/irqb_sense.sv
module irqb_sense #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_n_i,
  output logic [NLINES-1:0] active_o,
  output logic [NLINES-1:0] fresh_o
);

  logic [NLINES-1:0] seen_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic asserted;
    assign asserted = ~req_n_i[g];

    always_ff @(posedge clk) begin
      if (!rst_n) seen_q[g] <= 1'b0;
      else        seen_q[g] <= asserted;
    end

    // new assertion event: low now, not recorded low before
    assign fresh_o[g] = asserted & ~seen_q[g];
  end

  assign active_o = seen_q;

endmodule

// File: rtl/irqb_cfg.sv
module irqb_cfg
  import irqb_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CFG_PRIO_LSB+PRIO_W-1:0] wbits_i,
  output logic [NLINES*PRIO_W-1:0] prio_o,
  output logic [NLINES-1:0]        level_o,
  output logic [NLINES-1:0]        steer_o,
  output logic                     cfg_hit_o,
  output logic                     cfg_wr_o,
  output logic [DATA_W-1:0]        cfg_word_o
);

  localparam int CFG_W = CFG_PRIO_LSB + PRIO_W;

  function automatic logic [DATA_W-1:0] cfg_pack(
    input logic [PRIO_W-1:0] p, input logic lv, input logic st);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CFG_PRIO_LSB +: PRIO_W] = p;
    w[CFG_SENSE_BIT]          = lv;
    w[CFG_STEER_BIT]          = st;
    return w;
  endfunction

  logic [NLINES-1:0]   hit;
  logic [PRIO_W-1:0]   prio_q [NLINES];
  logic [NLINES-1:0]   level_q;
  logic [NLINES-1:0]   steer_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam int MY_OFF = OFF_CFG_BASE + 4 * g;
    assign hit[g] = (addr_i == MY_OFF[ADDR_W-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[g]  <= '0;
        level_q[g] <= SENSE_EDGE;
        steer_q[g] <= 1'b0;
      end else if (wr_en_i && hit[g]) begin
        prio_q[g]  <= wbits_i[CFG_PRIO_LSB +: PRIO_W];
        level_q[g] <= wbits_i[CFG_SENSE_BIT];
        steer_q[g] <= wbits_i[CFG_STEER_BIT];
      end
    end

    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];

    // a write aimed elsewhere leaves this line untouched
    AST_CFG_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en_i && hit[g])) |=> ($stable(prio_q[g]) && $stable(level_q[g]) && $stable(steer_q[g]))); // R2
  end

  assign level_o   = level_q;
  assign steer_o   = steer_q;
  assign cfg_hit_o = |hit;
  assign cfg_wr_o  = wr_en_i && (|hit);

  always_comb begin
    cfg_word_o = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (hit[i]) cfg_word_o = cfg_pack(prio_q[i], level_q[i], steer_q[i]);
    end
  end

  // the packed word never carries bits above the configuration field
  AST_CFG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_o >> CFG_W) == '0); // R2

endmodule

// File: rtl/irqb_pend.sv
module irqb_pend #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] fresh_i,
  input  logic [NLINES-1:0] active_i,
  input  logic [NLINES-1:0] level_i,
  input  logic              clr_wr_i,
  input  logic              sw_wr_i,
  input  logic              mask_wr_i,
  input  logic              cfg_wr_i,
  input  logic [NLINES-1:0] wval_i,
  input  logic [NLINES-1:0] ack_clr_i,
  output logic [NLINES-1:0] pend_o,
  output logic [NLINES-1:0] mask_o,
  output logic              reeval_o
);

  logic [NLINES-1:0] pend_q, pend_d, mask_q, keep, sw_set;
  logic              reeval_q;

  // bits that survive a pending-clear write: written ones plus held level lines
  function automatic logic [NLINES-1:0] clear_keep(
    input logic [NLINES-1:0] val, input logic [NLINES-1:0] raw,
    input logic [NLINES-1:0] lvl);
    return val | (raw & lvl);
  endfunction

  assign keep   = clr_wr_i ? clear_keep(wval_i, active_i, level_i) : '1;
  assign sw_set = sw_wr_i ? wval_i : '0;
  assign pend_d = ((pend_q & keep) & ~ack_clr_i) | fresh_i | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mask_q   <= '1;
      reeval_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      if (mask_wr_i) mask_q <= wval_i;
      reeval_q <= (pend_d != pend_q) || mask_wr_i || cfg_wr_i;
    end
  end

  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign reeval_o = reeval_q;

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((pend_q & $past(pend_q & active_i & level_i)) == $past(pend_q & active_i & level_i))); // R3

  AST_EDGE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i) |=> ((pend_q & ~$past(pend_q) & $past(active_i)) == '0)); // R5

  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> ((pend_q & $past(wval_i)) == $past(wval_i))); // R6

  AST_REEVAL_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != $past(pend_q)) |-> reeval_q); // R8

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irqb_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        req_n_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [IDX_W-1:0]         irq_win_i,
  input  logic [IDX_W-1:0]         fiq_win_i,
  output logic [NLINES-1:0]        pend_o,
  output logic [NLINES-1:0]        mask_o,
  output logic [NLINES-1:0]        steer_o,
  output logic [NLINES*PRIO_W-1:0] prio_o,
  output logic                     reeval_o
);

  localparam int CFG_W = CFG_PRIO_LSB + PRIO_W;

  function automatic logic [NLINES-1:0] line_bit(input logic [IDX_W-1:0] idx);
    logic [NLINES-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int off);
    return a == off[ADDR_W-1:0];
  endfunction

  // decoded access events
  logic clr_wr, sw_wr, mask_wr, irq_rd, fiq_rd;
  assign clr_wr  = wr_en_i && sel(addr_i, OFF_PEND);
  assign mask_wr = wr_en_i && sel(addr_i, OFF_MASK);
  assign sw_wr   = wr_en_i && sel(addr_i, OFF_SWSET);
  assign irq_rd  = rd_en_i && sel(addr_i, OFF_IRQ_CODE);
  assign fiq_rd  = rd_en_i && sel(addr_i, OFF_FIQ_CODE);

  logic [NLINES-1:0] active_w, fresh_w, level_w, pend_w, ack_clr;
  logic              cfg_hit, cfg_wr;
  logic [DATA_W-1:0] cfg_word;

  irqb_sense #(.NLINES(NLINES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n_i  (req_n_i),
    .active_o (active_w),
    .fresh_o  (fresh_w)
  );

  irqb_cfg #(.NLINES(NLINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wbits_i    (wdata_i[CFG_W-1:0]),
    .prio_o     (prio_o),
    .level_o    (level_w),
    .steer_o    (steer_o),
    .cfg_hit_o  (cfg_hit),
    .cfg_wr_o   (cfg_wr),
    .cfg_word_o (cfg_word)
  );

  // code-read acknowledge: only edge-sensitive winners are cleared
  logic irq_ack, fiq_ack;
  assign irq_ack = irq_rd && (level_w[irq_win_i] == SENSE_EDGE);
  assign fiq_ack = fiq_rd && (level_w[fiq_win_i] == SENSE_EDGE);
  assign ack_clr = (irq_ack ? line_bit(irq_win_i) : '0) |
                   (fiq_ack ? line_bit(fiq_win_i) : '0);

  irqb_pend #(.NLINES(NLINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .fresh_i   (fresh_w),
    .active_i  (active_w),
    .level_i   (level_w),
    .clr_wr_i  (clr_wr),
    .sw_wr_i   (sw_wr),
    .mask_wr_i (mask_wr),
    .cfg_wr_i  (cfg_wr),
    .wval_i    (wdata_i[NLINES-1:0]),
    .ack_clr_i (ack_clr),
    .pend_o    (pend_w),
    .mask_o    (mask_o),
    .reeval_o  (reeval_o)
  );

  assign pend_o = pend_w;

  always_comb begin
    rdata_o = '0;
    if (sel(addr_i, OFF_PEND))          rdata_o = DATA_W'(pend_w);
    else if (sel(addr_i, OFF_MASK))     rdata_o = DATA_W'(mask_o);
    else if (sel(addr_i, OFF_RAW))      rdata_o = DATA_W'(active_w);
    else if (sel(addr_i, OFF_IRQ_CODE)) rdata_o = DATA_W'(irq_win_i);
    else if (sel(addr_i, OFF_FIQ_CODE)) rdata_o = DATA_W'(fiq_win_i);
    else if (cfg_hit)                   rdata_o = cfg_word;
  end

  AST_ACK_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && level_w[irq_win_i] == SENSE_EDGE && !fresh_w[irq_win_i])
      |=> !pend_w[$past(irq_win_i)]); // R4

  AST_ACK_LEVEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && level_w[irq_win_i] == SENSE_LEVEL && pend_w[irq_win_i])
      |=> pend_w[$past(irq_win_i)]); // R9

  AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr) |=> $stable(mask_o)); // R7

endmodule

// File: tb/irq_line_bank_test.sv
`timescale 1ns/1ps
module irq_line_bank_test;

  localparam int NL = 32;
  localparam int PW = 5;
  localparam int VW = 143;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req_n = '1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [4:0]    irq_win = '0, fiq_win = '0;
  logic [NL-1:0] pend, mask, steer;
  logic [NL*PW-1:0] prio;
  logic          reeval;

  int nchk = 0, nfail = 0;
  logic finished = 1'b0;
  logic [31:0] rd_seen;

  always #2.5 clk = ~clk;

  irq_line_bank uut (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_win_i(irq_win),
    .fiq_win_i(fiq_win), .pend_o(pend), .mask_o(mask), .steer_o(steer),
    .prio_o(prio), .reeval_o(reeval)
  );

  // fields: req_n | op(0 idle,1 write,2 read) | addr | wdata | winner | exp rdata | exp pend
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'hFFFF_FFFF, 2'd0, 8'h00, 32'h0,         5'd0,  32'h0,         32'h0},
    {32'hFFFF_FFFE, 2'd0, 8'h00, 32'h0,         5'd0,  32'h0,         32'h1},
    {32'hFFFF_FFFE, 2'd1, 8'h00, 32'h0,         5'd0,  32'h0,         32'h0},
    {32'hFFFF_FFFF, 2'd0, 8'h00, 32'h0,         5'd0,  32'h0,         32'h0},
    {32'hFFFF_FFFE, 2'd0, 8'h00, 32'h0,         5'd0,  32'h0,         32'h1},
    {32'hFFFF_FFFA, 2'd2, 8'h10, 32'h0,         5'd0,  32'h0,         32'h4},
    {32'hFFFF_FFFF, 2'd1, 8'h0C, 32'h8000_0000, 5'd0,  32'h0,         32'h8000_0004},
    {32'hFFFF_FFFF, 2'd2, 8'h00, 32'h0,         5'd0,  32'h8000_0004, 32'h8000_0004},
    {32'hFFFF_FFFF, 2'd1, 8'h04, 32'h0000_FFFF, 5'd0,  32'h0,         32'h8000_0004},
    {32'hFFFF_FFFF, 2'd1, 8'h00, 32'h8000_0000, 5'd0,  32'h0,         32'h8000_0000},
    {32'hFFFF_FFFF, 2'd2, 8'h14, 32'h0,         5'd31, 32'd31,        32'h0},
    {32'hFFFF_FF0F, 2'd2, 8'h08, 32'h0,         5'd0,  32'h0,         32'hF0},
    {32'hFFFF_FF0F, 2'd1, 8'h00, 32'h0,         5'd0,  32'h0,         32'h0},
    {32'hFFFF_FF0F, 2'd2, 8'h08, 32'h0,         5'd0,  32'hF0,        32'h0}
  };

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [31:0] rq, input logic [1:0] op, input logic [7:0] a,
                      input logic [31:0] d, input logic [4:0] w);
    req_n = rq; addr = a; wdata = d; irq_win = w; fiq_win = w;
    wr_en = (op == 2'd1); rd_en = (op == 2'd2);
    #1 rd_seen = rdata;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state R1
    check("R1 pend", pend, 0);
    check("R1 mask", mask, 32'hFFFF_FFFF);
    check("R1 prio", prio, 0);
    check("R1 steer", steer, 0);
    check("R1 reeval", reeval, 0);
    step('1, 2'd2, 8'h30, 0, 0);
    check("R1 cfg line5 read", rd_seen, 0);
    step('1, 2'd2, 8'h08, 0, 0);
    check("R1 raw read", rd_seen, 0);

    // vector table: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[142:111], v[110:109], v[108:101], v[100:69], v[68:64]);
      if (v[110:109] == 2'd2) check("R4/R10 vector read", rd_seen, v[63:32]);
      check("R3/R5/R6 vector pend", pend, v[31:0]);
    end

    // R7 mask readback
    step('1, 2'd2, 8'h04, 0, 0);
    check("R7 mask read", rd_seen, 32'h0000_FFFF);
    check("R7 mask port", mask, 32'h0000_FFFF);

    // R2 configuration of line 3: prio 31, level, fast channel
    step('1, 2'd1, 8'h28, 32'hFFFF_FFFF, 0);
    check("R8 reeval after cfg write", reeval, 1);
    step('1, 2'd2, 8'h28, 0, 0);
    check("R2 cfg readback", rd_seen, 32'h7F);
    check("R2 prio line3", prio[3*PW +: PW], 5'd31);
    check("R2 prio line2 untouched", prio[2*PW +: PW], 5'd0);
    check("R2 steer", steer, 32'h8);
    check("R8 reeval idle", reeval, 0);

    // R3 level line keeps pending while request is low
    step(~32'h8, 2'd0, 8'h00, 0, 0);
    check("R5 level line raised", pend, 32'h8);
    step(~32'h8, 2'd1, 8'h00, 32'h0, 0);
    check("R3 clear blocked while asserted", pend, 32'h8);
    step('1, 2'd0, 8'h00, 0, 0);
    check("R3 latched after release", pend, 32'h8);
    step('1, 2'd1, 8'h00, 32'h0, 0);
    check("R3 clear after release", pend, 32'h0);

    // R9 level winner not acknowledged by code read
    step(~32'h8, 2'd0, 8'h00, 0, 0);
    check("R9 raised", pend, 32'h8);
    step('1, 2'd2, 8'h10, 0, 5'd3);
    check("R4 code value", rd_seen, 32'd3);
    check("R9 level kept", pend, 32'h8);

    // R8 mask write pulse
    step('1, 2'd1, 8'h04, 32'hFFFF_0000, 0);
    check("R8 reeval after mask write", reeval, 1);
    check("R7 mask port new", mask, 32'hFFFF_0000);
    step('1, 2'd0, 8'h00, 0, 0);
    check("R8 reeval quiet", reeval, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule